// File: doc/BRIEF.md
# Seconds Timekeeper with Alarm and Interrupts

This block keeps wall-clock time as a 32-bit count of seconds. It runs directly from a slow crystal clock of about 33.33 kHz. A prescaler counts crystal cycles up to a programmable limit and then advances the seconds counter. An optional fractional correction lengthens some seconds by one cycle, so the average rate can be trimmed in steps finer than one cycle per second. An alarm comparator flags the moment the seconds count reaches a programmed value. A small interrupt unit keeps a pending flag and an enable flag for each of its two sources, the once-per-second event and the alarm, and drives one line for each.

Software uses a plain 32-bit register port with separate write and read strobes and a byte offset. The port lets it load the time, trim the calibration, arm the alarm and service interrupts. The enable flags are never written directly: one offset turns sources on and another turns them off, each acting on the bits written as 1. Pending flags are cleared by writing 1s.

Top module: `rtc_core`

## Requirements
- R1: After reset: seconds 0, tick counter 0, alarm 0, pending 0, enables 0, calibration 0x198233, control reads 0x01000000 (oscillator on), `rdata` 0, both interrupt lines low.
- R2: A write to offset 0x08 stores the low 21 bits of `wdata` as the calibration word: bits 15:0 = cycle count N, bits 19:16 = fraction F, bit 20 = fraction enable. Offset 0x0C reads it back, zero-extended.
- R3: While the oscillator is on, the tick counter rises by one each clock. On an edge where it is already at or above the target (N, or N+1 for a long second), it returns to 0 and the seconds count rises by one. A plain second therefore lasts N+1 clocks. Offset 0x10 reads the seconds and offset 0x14 reads the tick counter, zero-extended.
- R4: With bit 20 set, a 4-bit accumulator gains F at each second rollover. A second is long (target N+1) when the accumulator plus F reaches 16. A calibration write clears the accumulator.
- R5: A write to offset 0x00 loads the seconds count, clears the tick counter and wins over a rollover on the same edge. Offset 0x04 returns the last value written there.
- R6: A read strobe updates `rdata` on the next clock edge with the state held before that edge, and `rdata` holds when there is no read. Offsets 0x00, 0x08, 0x28, 0x2C and unmapped offsets read as 0.
- R7: Pending bit 0 sets on every second rollover.
- R8: Pending bit 1 sets on the edge where the seconds count takes a value equal to the alarm at offset 0x18, by rollover or by a time load, whether or not it is enabled. The alarm offset is read/write.
- R9: Writing offset 0x20 clears the pending bits written as 1 and leaves those written as 0. A new event on the same edge wins over the clear.
- R10: Offset 0x24 reads the enable bits and ignores writes. Writing 1s to offset 0x28 sets the enable bits; writing 1s to offset 0x2C clears them.
- R11: `irq_sec` is high exactly when pending bit 0 and enable bit 0 are both set; `irq_alarm` does the same for bit 1.
- R12: Control offset 0x40 bit 24 is the oscillator enable and is the only bit that reads back. While it is 0 the tick and seconds counters hold, but a time load still takes effect.
- R13: If the calibration count is lowered below the current tick value, the second ends on the next edge instead of wrapping the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock, about 33.33 kHz |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_sec | output | 1 | Once-per-second interrupt line |
| irq_alarm | output | 1 | Alarm interrupt line |

## Verification
The calibration path is driven with a short plain count, a half-unit fraction that makes seconds alternate between two lengths, a full fraction, and fraction bits with the enable off. A stretched second then reads back a different seconds value than an unstretched one. A count lowered below the live tick value shows whether the prescaler wraps or ends the second at once. The interrupt unit is tried with the source enabled and disabled, with zero and one write-clears, and with a clear on every cycle while seconds roll over. That last pattern separates set-over-clear priority from clear-over-set. Alarms are hit both by a time load and by counting into the alarm value, with the oscillator both running and stopped.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // byte offsets seen by software; each one is decoded by driver code
  localparam logic [7:0] OFS_TSET_WR = 8'h00;
  localparam logic [7:0] OFS_TSET_RD = 8'h04;
  localparam logic [7:0] OFS_CAL_WR  = 8'h08;
  localparam logic [7:0] OFS_CAL_RD  = 8'h0C;
  localparam logic [7:0] OFS_NOW     = 8'h10;
  localparam logic [7:0] OFS_TICK    = 8'h14;
  localparam logic [7:0] OFS_ALARM   = 8'h18;
  localparam logic [7:0] OFS_PEND    = 8'h20;
  localparam logic [7:0] OFS_ENMASK  = 8'h24;
  localparam logic [7:0] OFS_ENSET   = 8'h28;
  localparam logic [7:0] OFS_ENCLR   = 8'h2C;
  localparam logic [7:0] OFS_CTRL    = 8'h40;

  localparam int SRC_SEC   = 0;
  localparam int SRC_ALARM = 1;
  localparam int NUM_SRC   = 2;
  localparam int OSC_BIT   = 24;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICK_W = 16,
  parameter int FRAC_W = 4,
  localparam int CAL_W = TICK_W + FRAC_W + 1,
  localparam int CNT_W = TICK_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             set_we,
  input  logic             cal_we,
  input  logic [CAL_W-1:0] cal_q,
  output logic [CNT_W-1:0] tick_q,
  output logic             sec_tick
);
  logic [TICK_W-1:0] count;
  logic [FRAC_W-1:0] frac;
  logic              frac_en;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [FRAC_W:0]   acc_sum;
  logic              long_sec;
  logic [CNT_W-1:0]  target;
  logic              at_end;
  logic [CNT_W-1:0]  tick_d;
  logic              tick_ce, acc_ce;

  always_comb begin
    count    = cal_q[TICK_W-1:0];
    frac     = cal_q[TICK_W +: FRAC_W];
    frac_en  = cal_q[CAL_W-1];
    acc_sum  = {1'b0, acc_q} + {1'b0, frac};
    long_sec = frac_en & acc_sum[FRAC_W];
    target   = {1'b0, count} + CNT_W'(long_sec);
    // ">=" so a lowered count ends the second instead of wrapping
    at_end   = (tick_q >= target);
    sec_tick = osc_en & at_end & ~set_we;
  end

  always_comb begin
    tick_ce = set_we | osc_en;
    if (set_we)      tick_d = '0;
    else if (at_end) tick_d = '0;
    else             tick_d = tick_q + 1'b1;
    acc_ce = cal_we | (sec_tick & frac_en);
    acc_d  = cal_we ? '0 : acc_sum[FRAC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      acc_q  <= '0;
    end else begin
      if (tick_ce) tick_q <= tick_d;
      if (acc_ce)  acc_q  <= acc_d;
    end
  end
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic [DATA_W-1:0] set_val,
  input  logic              sec_tick,
  input  logic [DATA_W-1:0] alm_q,
  output logic [DATA_W-1:0] sec_q,
  output logic              alarm_hit
);
  logic [DATA_W-1:0] sec_d;
  logic              sec_ce;

  always_comb begin
    sec_ce    = set_we | sec_tick;
    sec_d     = set_we ? set_val : (sec_q + 1'b1);
    alarm_hit = sec_ce & (sec_d == alm_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sec_q <= '0;
    else if (sec_ce) sec_q <= sec_d;
  end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] event_in,
  input  logic            clr_we,
  input  logic            en_we,
  input  logic            dis_we,
  input  logic [NSRC-1:0] wbits,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] irq
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic pend_d, mask_d, pend_ce, mask_ce;

    always_comb begin
      pend_ce = event_in[i] | (clr_we & wbits[i]);
      pend_d  = event_in[i];              // an event wins over a clear
      mask_ce = (en_we | dis_we) & wbits[i];
      mask_d  = en_we;
      irq[i]  = pend_q[i] & mask_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[i] <= 1'b0;
        mask_q[i] <= 1'b0;
      end else begin
        if (pend_ce) pend_q[i] <= pend_d;
        if (mask_ce) mask_q[i] <= mask_d;
      end
    end
  end
endmodule

// File: rtl/rtc_bus_regs.sv
module rtc_bus_regs
  import rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int TICK_W = 16,
  parameter int FRAC_W = 4,
  parameter int NSRC   = 2,
  localparam int CAL_W = TICK_W + FRAC_W + 1,
  localparam int CNT_W = TICK_W + 1,
  parameter logic [CAL_W-1:0] CAL_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] sec_q,
  input  logic [CNT_W-1:0]  tick_q,
  input  logic [NSRC-1:0]   pend_q,
  input  logic [NSRC-1:0]   mask_q,
  output logic [DATA_W-1:0] rdata,
  output logic              set_we,
  output logic              cal_we,
  output logic              clr_we,
  output logic              en_we,
  output logic              dis_we,
  output logic [CAL_W-1:0]  cal_q,
  output logic [DATA_W-1:0] alm_q,
  output logic              osc_en
);
  logic              alm_we, ctrl_we;
  logic [DATA_W-1:0] setrb_q, rd_val;
  logic              osc_q;

  always_comb begin
    set_we  = wr_en && (addr == ADDR_W'(OFS_TSET_WR));
    cal_we  = wr_en && (addr == ADDR_W'(OFS_CAL_WR));
    alm_we  = wr_en && (addr == ADDR_W'(OFS_ALARM));
    clr_we  = wr_en && (addr == ADDR_W'(OFS_PEND));
    en_we   = wr_en && (addr == ADDR_W'(OFS_ENSET));
    dis_we  = wr_en && (addr == ADDR_W'(OFS_ENCLR));
    ctrl_we = wr_en && (addr == ADDR_W'(OFS_CTRL));
    osc_en  = osc_q;
  end

  always_comb begin
    rd_val = '0;
    case (addr)
      ADDR_W'(OFS_TSET_RD): rd_val = setrb_q;
      ADDR_W'(OFS_CAL_RD):  rd_val = DATA_W'(cal_q);
      ADDR_W'(OFS_NOW):     rd_val = sec_q;
      ADDR_W'(OFS_TICK):    rd_val = DATA_W'(tick_q);
      ADDR_W'(OFS_ALARM):   rd_val = alm_q;
      ADDR_W'(OFS_PEND):    rd_val = DATA_W'(pend_q);
      ADDR_W'(OFS_ENMASK):  rd_val = DATA_W'(mask_q);
      ADDR_W'(OFS_CTRL):    rd_val[OSC_BIT] = osc_q;
      default:              rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q   <= CAL_RST;
      alm_q   <= '0;
      setrb_q <= '0;
      osc_q   <= 1'b1;
      rdata   <= '0;
    end else begin
      if (cal_we)  cal_q   <= wdata[CAL_W-1:0];
      if (alm_we)  alm_q   <= wdata;
      if (set_we)  setrb_q <= wdata;
      if (ctrl_we) osc_q   <= wdata[OSC_BIT];
      if (rd_en)   rdata   <= rd_val;
    end
  end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int TICK_W = 16,
  parameter int FRAC_W = 4,
  localparam int CAL_W = TICK_W + FRAC_W + 1,
  localparam int CNT_W = TICK_W + 1,
  parameter logic [CAL_W-1:0] CAL_RST = CAL_W'(21'h198233)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_sec,
  output logic              irq_alarm
);
  logic [1:0]        rsync_q;
  logic              srst_n;
  logic              set_we, cal_we, clr_we, en_we, dis_we, osc_en;
  logic [CAL_W-1:0]  cal_q;
  logic [DATA_W-1:0] alm_q, sec_q;
  logic [CNT_W-1:0]  tick_q;
  logic              sec_tick, alarm_hit;
  logic [NUM_SRC-1:0] events, pend_q, mask_q, irq_vec;

  // reset asserts at once, releases two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  rtc_bus_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TICK_W(TICK_W), .FRAC_W(FRAC_W),
    .NSRC(NUM_SRC), .CAL_RST(CAL_RST)
  ) regs_i (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .sec_q(sec_q), .tick_q(tick_q), .pend_q(pend_q),
    .mask_q(mask_q), .rdata(rdata), .set_we(set_we), .cal_we(cal_we),
    .clr_we(clr_we), .en_we(en_we), .dis_we(dis_we), .cal_q(cal_q),
    .alm_q(alm_q), .osc_en(osc_en)
  );

  rtc_prescaler #(.TICK_W(TICK_W), .FRAC_W(FRAC_W)) presc_i (
    .clk(clk), .rst_n(srst_n), .osc_en(osc_en), .set_we(set_we),
    .cal_we(cal_we), .cal_q(cal_q), .tick_q(tick_q), .sec_tick(sec_tick)
  );

  rtc_timekeeper #(.DATA_W(DATA_W)) time_i (
    .clk(clk), .rst_n(srst_n), .set_we(set_we), .set_val(wdata),
    .sec_tick(sec_tick), .alm_q(alm_q), .sec_q(sec_q), .alarm_hit(alarm_hit)
  );

  always_comb begin
    events            = '0;
    events[SRC_SEC]   = sec_tick;
    events[SRC_ALARM] = alarm_hit;
  end

  rtc_irq_ctrl #(.NSRC(NUM_SRC)) irq_i (
    .clk(clk), .rst_n(srst_n), .event_in(events), .clr_we(clr_we),
    .en_we(en_we), .dis_we(dis_we), .wbits(wdata[NUM_SRC-1:0]),
    .pend_q(pend_q), .mask_q(mask_q), .irq(irq_vec)
  );

  assign irq_sec   = irq_vec[SRC_SEC];
  assign irq_alarm = irq_vec[SRC_ALARM];
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk #(
  parameter int DATA_W = 32,
  parameter int TICK_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              set_we,
  input logic              osc_en,
  input logic [DATA_W-1:0] sec_q,
  input logic [TICK_W:0]   tick_q,
  input logic [DATA_W-1:0] alm_q,
  input logic              alarm_hit,
  input logic [1:0]        pend_q,
  input logic [1:0]        mask_q,
  input logic              clr_we,
  input logic              en_we,
  input logic              dis_we,
  input logic [1:0]        wbits,
  input logic              irq_alarm
);
  // R3: without a load, seconds only ever move up by one
  assert_sec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(set_we) && (sec_q != $past(sec_q))) |-> (sec_q == $past(sec_q) + 1'b1));

  // R8: an alarm match leaves seconds equal to the alarm and the flag pending
  assert_alarm_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> ((sec_q == $past(alm_q)) && pend_q[1]));

  // R9: a pending flag survives unless a 1 is written to it
  assert_pend_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[1] && !(clr_we && wbits[1])) |=> pend_q[1]);

  assert_pend_sec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[0] && !(clr_we && wbits[0])) |=> pend_q[0]);

  // R10: enable bits move only through the set/clear offsets
  assert_mask_path_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mask_q) |-> $past(en_we || dis_we));

  // R11: the alarm line rises only after a match or an enable
  assert_alarm_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_alarm) |-> $past(alarm_hit || (en_we && wbits[1])));

  // R12: a stopped oscillator freezes both counters
  assert_osc_freeze_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !set_we) |=> ($stable(tick_q) && $stable(sec_q)));
endmodule

bind rtc_core rtc_core_chk #(.DATA_W(DATA_W), .TICK_W(TICK_W)) chk_i (
  .clk(clk), .rst_n(srst_n), .set_we(set_we), .osc_en(osc_en),
  .sec_q(sec_q), .tick_q(tick_q), .alm_q(alm_q), .alarm_hit(alarm_hit),
  .pend_q(pend_q), .mask_q(mask_q), .clr_we(clr_we), .en_we(en_we),
  .dis_we(dis_we), .wbits(wdata[1:0]), .irq_alarm(irq_alarm)
);

// File: tb/rtc_core_tb_top.sv
module rtc_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 50000;

  logic        clk, rst_n, wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq_sec, irq_alarm;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;
  bit started  = 0;

  rtc_core dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_sec(irq_sec), .irq_alarm(irq_alarm)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference ----------------
  bit [31:0] m_sec, m_alm, m_setrb, m_rdata;
  int        m_tick, m_acc, rs_cnt;
  bit [20:0] m_cal;
  bit        m_osc;
  bit [1:0]  m_pend, m_mask;
  bit [7:0]  m_last_addr;

  task automatic model_reset();
    m_sec = 0; m_alm = 0; m_setrb = 0; m_rdata = 0;
    m_tick = 0; m_acc = 0; m_cal = 21'h198233; m_osc = 1;
    m_pend = 0; m_mask = 0; m_last_addr = 8'h00;
  endtask

  function automatic bit [31:0] model_read(bit [7:0] a);
    case (a)
      8'h04: return m_setrb;
      8'h0C: return 32'(m_cal);
      8'h10: return m_sec;
      8'h14: return 32'(m_tick);
      8'h18: return m_alm;
      8'h20: return 32'(m_pend);
      8'h24: return 32'(m_mask);
      8'h40: return m_osc ? 32'h0100_0000 : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(bit [7:0] a);
    case (a)
      8'h04: return "R5";
      8'h0C: return "R2";
      8'h10, 8'h14: return "R3";
      8'h18: return "R8";
      8'h20: return "R9";
      8'h24: return "R10";
      8'h40: return "R12";
      default: return "R6";
    endcase
  endfunction

  task automatic model_step();
    int  cnt, frac, tgt;
    bit  fen, chg, hit, roll;
    bit [31:0] n_sec;
    int  n_tick, n_acc;
    bit [1:0] ev, clr;
    cnt  = int'(m_cal[15:0]);
    frac = int'(m_cal[19:16]);
    fen  = m_cal[20];
    tgt  = cnt + ((fen && (m_acc + frac >= 16)) ? 1 : 0);
    n_sec = m_sec; n_tick = m_tick; n_acc = m_acc; chg = 0; roll = 0;
    if (wr_en && addr == 8'h00) begin
      n_sec = wdata; n_tick = 0; chg = 1;
    end else if (m_osc) begin
      if (m_tick >= tgt) begin
        n_tick = 0; n_sec = m_sec + 1; chg = 1; roll = 1;
        if (fen) n_acc = (m_acc + frac) % 16;
      end else n_tick = m_tick + 1;
    end
    hit = chg && (n_sec == m_alm);
    ev  = {hit, roll};
    clr = (wr_en && addr == 8'h20) ? wdata[1:0] : 2'b00;
    if (rd_en) begin m_rdata = model_read(addr); m_last_addr = addr; end
    m_pend = (m_pend & ~clr) | ev;
    if (wr_en && addr == 8'h28) m_mask = m_mask | wdata[1:0];
    if (wr_en && addr == 8'h2C) m_mask = m_mask & ~wdata[1:0];
    if (wr_en && addr == 8'h00) m_setrb = wdata;
    if (wr_en && addr == 8'h18) m_alm = wdata;
    if (wr_en && addr == 8'h40) m_osc = wdata[24];
    if (wr_en && addr == 8'h08) begin m_cal = wdata[20:0]; n_acc = 0; end
    m_sec = n_sec; m_tick = n_tick; m_acc = n_acc;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin rs_cnt = 0; model_reset(); end
    else if (rs_cnt < 2) begin rs_cnt++; model_reset(); end
    else model_step();
    started = 1;
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R11 irq_sec", 32'(irq_sec), 32'(m_pend[0] & m_mask[0]));
      chk("R11 irq_alarm", 32'(irq_alarm), 32'(m_pend[1] & m_mask[1]));
      chk({tag_of(m_last_addr), " rdata"}, rdata, m_rdata);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(bit [7:0] a, bit [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(bit [7:0] a);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    idle(4);
    rst_n = 1;
    idle(4);

    // R1 reset state
    chk("R1 irq_sec", 32'(irq_sec), 0);
    chk("R1 irq_alarm", 32'(irq_alarm), 0);
    chk("R1 rdata", rdata, 0);
    rd(8'h0C); chk("R1 calibration", rdata, 32'h0019_8233);
    rd(8'h40); chk("R1 control", rdata, 32'h0100_0000);
    rd(8'h24); chk("R1 enables", rdata, 0);
    rd(8'h10); chk("R1 seconds", rdata, 0);

    // R3 plain seconds of N+1 clocks
    wr(8'h08, 32'd4);
    wr(8'h00, 32'd100);
    idle(25);
    rd(8'h10); chk("R3 seconds after 25 clocks", rdata, 32'd105);

    // R4 half-unit fraction: seconds of 4 and 5 clocks alternate
    wr(8'h08, (32'd1 << 20) | (32'd8 << 16) | 32'd3);
    wr(8'h00, 32'd0);
    idle(36);
    rd(8'h10); chk("R4 seconds with fraction", rdata, 32'd8);
    wr(8'h08, (32'd1 << 20) | (32'd15 << 16) | 32'd3);
    idle(80);
    wr(8'h08, (32'd7 << 16) | 32'd2);
    idle(30);

    // R13 count lowered under the live tick value
    wr(8'h08, 32'd20);
    wr(8'h00, 32'd0);
    idle(10);
    wr(8'h08, 32'd2);
    idle(1);
    rd(8'h10); chk("R13 second ends at once", rdata, 32'd1);

    // R7 R9 R11 seconds source
    wr(8'h08, 32'd3);
    wr(8'h00, 32'd10);
    idle(10);
    wr(8'h08, 32'd1000);
    wr(8'h00, 32'd10);
    wr(8'h20, 32'd2);
    chk("R11 masked seconds line", 32'(irq_sec), 0);
    rd(8'h20); chk("R7 seconds pending", rdata, 32'd1);
    wr(8'h28, 32'd1); chk("R11 enabled seconds line", 32'(irq_sec), 1);
    wr(8'h20, 32'd0); chk("R9 zero write keeps", 32'(irq_sec), 1);
    wr(8'h20, 32'd1); chk("R9 one write clears", 32'(irq_sec), 0);

    // R8 R10 alarm by time load
    wr(8'h18, 32'd50);
    wr(8'h00, 32'd50);
    chk("R8 masked alarm line", 32'(irq_alarm), 0);
    rd(8'h20); chk("R8 alarm pending while masked", rdata, 32'd2);
    wr(8'h28, 32'd2); chk("R11 enabled alarm line", 32'(irq_alarm), 1);
    wr(8'h2C, 32'd2); chk("R10 disable drops line", 32'(irq_alarm), 0);
    rd(8'h24); chk("R10 enable readback", rdata, 32'd1);
    wr(8'h24, 32'd3);
    rd(8'h24); chk("R10 write to enable readback ignored", rdata, 32'd1);
    wr(8'h20, 32'd2);

    // R5 R6 readbacks
    rd(8'h04); chk("R5 load readback", rdata, 32'd50);
    rd(8'h00); chk("R6 write-only load", rdata, 0);
    rd(8'h28); chk("R6 write-only enable", rdata, 0);
    rd(8'h3C); chk("R6 unmapped", rdata, 0);
    rd(8'h08); chk("R6 write-only calibration", rdata, 0);

    // R12 oscillator stop
    wr(8'h40, 32'd0);
    rd(8'h14);
    begin
      logic [31:0] t0;
      t0 = rdata;
      idle(20);
      rd(8'h14); chk("R12 tick frozen", rdata, t0);
    end
    rd(8'h10); chk("R12 seconds frozen", rdata, 32'd50);
    rd(8'h40); chk("R12 control off", rdata, 0);
    wr(8'h00, 32'd7);
    rd(8'h10); chk("R12 load while stopped", rdata, 32'd7);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40); chk("R12 only bit 24 kept", rdata, 32'h0100_0000);

    // R2 calibration width
    wr(8'h08, 32'hFFE1_2345);
    rd(8'h0C); chk("R2 calibration masked to 21 bits", rdata, 32'h0001_2345);

    // R8 alarm reached by counting
    wr(8'h08, 32'd2);
    wr(8'h28, 32'd2);
    wr(8'h18, 32'd20);
    wr(8'h00, 32'd17);
    idle(15);
    chk("R8 alarm by rollover", 32'(irq_alarm), 1);

    // R9 clear on every cycle while seconds keep rolling
    wr(8'h28, 32'd1);
    for (int i = 0; i < 30; i++) wr(8'h20, 32'd1);
    idle(10);

    finish_run();
  end
endmodule